// File: doc/BRIEF.md
# Eight-Way Tree Replacement Selector with Line Locking

This block holds the replacement history of a set-associative cache with 1024 sets of eight ways. On a fill it names the way to evict, and on a hit it records the access. The history is a seven-bit binary tree per set. Each access turns the bits on its path to point away from the way it used. The tree's choice is the victim unless that way is locked. A locked way is never returned.

Locks are kept per line in two independent domains, one for instruction fills and one for data fills. Commands set or clear one lock bit at a time. Two level inputs freeze allocation for a whole domain. A single flash-clear pulse erases every lock in both domains. It does so by sweeping the sets, one per cycle, while a busy output stays high. The surrounding cache controller supplies the set index with each request and uses the answer to pick the line it overwrites.

Top module: `plru_lock_victim`

## Requirements
- R1: After reset every tree is all zeros, every lock is clear, `vic_vld` and `flash_busy` are low, and the first fill to any set returns way 0.
- R2: A fill request sampled at a clock edge produces `vic_vld` high for exactly the following cycle. `vic_vld` is low in any cycle that does not follow a fill request.
- R3: Tree node 0 is the root and node n has children 2n+1 and 2n+2; bit value 0 means go to the lower-numbered half. The walk reads the way number from the most significant bit down, so with no hits and no locks a set yields the victims 0, 4, 2, 6 in that order.
- R4: A hit on way w (with no fill in that cycle) sets each node on w's path to the inverse of w's bit at that level, so the next walk leads away from w.
- R5: When a fill and a hit arrive in the same cycle, the fill updates the tree and the hit is dropped.
- R6: When the way the tree selects is locked in the fill's domain, the victim is the lowest-numbered unlocked way of that domain. The tree is then updated toward the way actually returned.
- R7: Instruction locks affect only fills with `fill_instr` = 1, and data locks affect only fills with `fill_instr` = 0.
- R8: A lock command with `lk_set` = 0 clears the addressed lock bit, so that way becomes eligible again.
- R9: When all eight ways of the set are locked in the fill's domain, the response has `vic_none` high and the tree of that set is left unchanged.
- R10: While `cache_lock_instr` (or `cache_lock_data`) is high, fills of that domain answer with `vic_none` high and change no state. Fills of the other domain are unaffected.
- R11: A flash-clear pulse raises `flash_busy` in the next cycle. `flash_busy` stays high for exactly 1024 cycles, and afterwards every lock in both domains is clear.
- R12: While `flash_busy` is high, fills answer with `vic_none` high and change no tree, and lock commands and further flash-clear pulses are ignored.
- R13: Sets are independent; operations on one set never alter another set's tree or locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_idx | input | 10 | Set addressed by the fill, hit or lock command |
| hit_vld | input | 1 | Record a hit on `hit_way` |
| hit_way | input | 3 | Way that hit |
| fill_req | input | 1 | Request a victim for a fill |
| fill_instr | input | 1 | 1: instruction fill, 0: data fill |
| lk_vld | input | 1 | Apply a per-line lock command |
| lk_set | input | 1 | 1: set lock, 0: clear lock |
| lk_instr | input | 1 | 1: instruction domain, 0: data domain |
| lk_way | input | 3 | Way whose lock is written |
| cache_lock_instr | input | 1 | Freeze all instruction allocation |
| cache_lock_data | input | 1 | Freeze all data allocation |
| flash_clr | input | 1 | Pulse to erase every lock |
| vic_vld | output | 1 | Fill response valid |
| vic_none | output | 1 | No way can be evicted |
| vic_way | output | 3 | Chosen victim way |
| flash_busy | output | 1 | Lock sweep in progress |

## Verification
On every cycle the assertions check several rules. A response follows each fill and no other cycle. A returned way is never locked, and a no-victim answer always has a lock-based cause. A touched way is never the next pick of its set. A sweep starts only after a request, and frozen or busy fills are refused. Only the bench's scenarios can show the exact victim order of the tree, the lowest-free fallback, the separation of the two domains, and that a refused fill leaves the tree untouched. They also show the 1024-cycle sweep length and that commands issued during the sweep are lost.

// File: rtl/plru_lock_pkg.sv
package plru_lock_pkg;

    localparam int WAY_W  = 3;
    localparam int WAYS   = 1 << WAY_W;
    localparam int TREE_W = WAYS - 1;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [TREE_W-1:0] tree_t;
    typedef logic [WAYS-1:0]   wmask_t;

    typedef enum logic {
        DOM_DATA  = 1'b0,
        DOM_INSTR = 1'b1
    } dom_e;

    typedef struct packed {
        logic vld;
        logic set_lk;
        dom_e dom;
        way_t way;
    } lk_cmd_t;

    typedef struct packed {
        logic vld;
        logic none;
        way_t way;
    } vic_rsp_t;

    // Follow the tree from the root; each node bit gives one way bit, MSB first.
    function automatic way_t tree_walk(tree_t t);
        way_t w;
        int   node;
        w    = '0;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            w[WAY_W-1-lvl] = t[node];
            node = 2 * node + 1 + int'(t[node]);
        end
        return w;
    endfunction

    // Make every node on the path of way w point to the other subtree.
    function automatic tree_t tree_touch(tree_t t, way_t w);
        tree_t r;
        int    node;
        r    = t;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            r[node] = ~w[WAY_W-1-lvl];
            node = 2 * node + 1 + int'(w[WAY_W-1-lvl]);
        end
        return r;
    endfunction

    // Lowest-numbered way whose lock bit is clear.
    function automatic way_t first_free(wmask_t locked);
        way_t w;
        w = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!locked[i]) w = way_t'(i);
        end
        return w;
    endfunction

endpackage

// File: rtl/plru_tree_store.sv
module plru_tree_store
    import plru_lock_pkg::*;
#(
    parameter  int NUM_SETS = 1024,
    localparam int SET_W    = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic             upd_en,
    input  way_t             upd_way,
    output tree_t            cur_tree
);

    tree_t mem [NUM_SETS];

    assign cur_tree = mem[set_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) mem[s] <= '0;
        end else if (upd_en) begin
            mem[set_idx] <= tree_touch(mem[set_idx], upd_way);
        end
    end

    // R4
    touched_away_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (tree_walk(mem[$past(set_idx)]) != $past(upd_way)));

endmodule

// File: rtl/plru_lock_store.sv
module plru_lock_store
    import plru_lock_pkg::*;
#(
    parameter  int NUM_SETS = 1024,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int NUM_DOM  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  lk_cmd_t          cmd,
    input  logic             flash_req,
    output wmask_t           ilock_row,
    output wmask_t           dlock_row,
    output logic             busy
);

    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

    logic             busy_q;
    logic [SET_W-1:0] sweep_ptr;
    wmask_t           rows [NUM_DOM];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            sweep_ptr <= '0;
        end else if (busy_q) begin
            sweep_ptr <= sweep_ptr + 1'b1;
            if (sweep_ptr == LAST_SET) busy_q <= 1'b0;
        end else if (flash_req) begin
            busy_q    <= 1'b1;
            sweep_ptr <= '0;
        end
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        localparam logic IS_INSTR = (d == 1);
        wmask_t lk_mem [NUM_SETS];
        logic   hit_dom;

        assign hit_dom = cmd.vld && ((cmd.dom == DOM_INSTR) == IS_INSTR);
        assign rows[d] = lk_mem[set_idx];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < NUM_SETS; s++) lk_mem[s] <= '0;
            end else if (busy_q) begin
                lk_mem[sweep_ptr] <= '0;
            end else if (hit_dom) begin
                lk_mem[set_idx][cmd.way] <= cmd.set_lk;
            end
        end
    end

    assign ilock_row = rows[1];
    assign dlock_row = rows[0];
    assign busy      = busy_q;

    // R11
    sweep_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(flash_req));

    // R11
    sweep_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> (sweep_ptr == '0));

endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
    import plru_lock_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  tree_t  tree,
    input  wmask_t locked,
    input  logic   blocked,
    output logic   none,
    output way_t   way
);

    way_t tree_way;

    always_comb begin
        tree_way = tree_walk(tree);
        none     = 1'b0;
        way      = tree_way;
        if (blocked || (&locked)) begin
            none = 1'b1;
        end else if (locked[tree_way]) begin
            way = first_free(locked);
        end
    end

    // R6
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        !none |-> !locked[way]);

    // R9
    none_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        none |-> (blocked || (&locked)));

endmodule

// File: rtl/plru_lock_victim.sv
module plru_lock_victim
    import plru_lock_pkg::*;
#(
    parameter  int NUM_SETS = 1024,
    localparam int SET_W    = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic             hit_vld,
    input  logic [2:0]       hit_way,
    input  logic             fill_req,
    input  logic             fill_instr,
    input  logic             lk_vld,
    input  logic             lk_set,
    input  logic             lk_instr,
    input  logic [2:0]       lk_way,
    input  logic             cache_lock_instr,
    input  logic             cache_lock_data,
    input  logic             flash_clr,
    output logic             vic_vld,
    output logic             vic_none,
    output logic [2:0]       vic_way,
    output logic             flash_busy
);

    lk_cmd_t  cmd;
    wmask_t   irow, drow, fill_mask;
    tree_t    cur_tree;
    logic     busy, blocked, pick_none, upd_en;
    way_t     pick_way, upd_way;
    vic_rsp_t rsp_q;

    assign cmd = '{vld: lk_vld, set_lk: lk_set,
                   dom: (lk_instr ? DOM_INSTR : DOM_DATA), way: lk_way};

    plru_lock_store #(.NUM_SETS(NUM_SETS)) u_locks (
        .clk       (clk),
        .rst       (rst),
        .set_idx   (set_idx),
        .cmd       (cmd),
        .flash_req (flash_clr),
        .ilock_row (irow),
        .dlock_row (drow),
        .busy      (busy)
    );

    assign fill_mask = fill_instr ? irow : drow;
    assign blocked   = busy || (fill_instr ? cache_lock_instr : cache_lock_data);

    plru_victim_pick u_pick (
        .clk     (clk),
        .rst     (rst),
        .tree    (cur_tree),
        .locked  (fill_mask),
        .blocked (blocked),
        .none    (pick_none),
        .way     (pick_way)
    );

    assign upd_en  = fill_req ? !pick_none : hit_vld;
    assign upd_way = fill_req ? pick_way : hit_way;

    plru_tree_store #(.NUM_SETS(NUM_SETS)) u_tree (
        .clk      (clk),
        .rst      (rst),
        .set_idx  (set_idx),
        .upd_en   (upd_en),
        .upd_way  (upd_way),
        .cur_tree (cur_tree)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= '{vld:  fill_req,
                       none: fill_req && pick_none,
                       way:  (fill_req && !pick_none) ? pick_way : '0};
        end
    end

    assign vic_vld    = rsp_q.vld;
    assign vic_none   = rsp_q.none;
    assign vic_way    = rsp_q.way;
    assign flash_busy = busy;

    // R2
    rsp_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> vic_vld);

    // R2
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !fill_req |=> !vic_vld);

    // R10
    instr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && fill_instr && cache_lock_instr) |=> vic_none);

    // R10
    data_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_instr && cache_lock_data) |=> vic_none);

    // R12
    busy_fill_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && flash_busy) |=> vic_none);

endmodule

// File: tb/plru_lock_victim_tb.sv
module plru_lock_victim_tb;

    typedef struct packed {
        logic [2:0] op;    // 0 instr fill, 1 data fill, 2 hit, 3/4 lock I/D, 5/6 unlock I/D
        logic [9:0] set;
        logic [2:0] way;
        logic       enone;
        logic [2:0] eway;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 10'd3, 3'd0, 1'b0, 3'd0},
        '{3'd1, 10'd3, 3'd0, 1'b0, 3'd4},
        '{3'd1, 10'd3, 3'd0, 1'b0, 3'd2},
        '{3'd1, 10'd3, 3'd0, 1'b0, 3'd6},
        '{3'd1, 10'd7, 3'd0, 1'b0, 3'd0},
        '{3'd2, 10'd3, 3'd1, 1'b0, 3'd0},
        '{3'd1, 10'd3, 3'd0, 1'b0, 3'd5},
        '{3'd4, 10'd3, 3'd3, 1'b0, 3'd0},
        '{3'd0, 10'd3, 3'd0, 1'b0, 3'd3},
        '{3'd4, 10'd3, 3'd7, 1'b0, 3'd0},
        '{3'd1, 10'd3, 3'd0, 1'b0, 3'd0},
        '{3'd0, 10'd3, 3'd0, 1'b0, 3'd7},
        '{3'd6, 10'd3, 3'd7, 1'b0, 3'd0},
        '{3'd1, 10'd3, 3'd0, 1'b0, 3'd2},
        '{3'd4, 10'd3, 3'd4, 1'b0, 3'd0},
        '{3'd1, 10'd3, 3'd0, 1'b0, 3'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] set_idx = '0;
    logic       hit_vld = 1'b0;
    logic [2:0] hit_way = '0;
    logic       fill_req = 1'b0;
    logic       fill_instr = 1'b0;
    logic       lk_vld = 1'b0;
    logic       lk_set = 1'b0;
    logic       lk_instr = 1'b0;
    logic [2:0] lk_way = '0;
    logic       cache_lock_instr = 1'b0;
    logic       cache_lock_data = 1'b0;
    logic       flash_clr = 1'b0;
    logic       vic_vld, vic_none, flash_busy;
    logic [2:0] vic_way;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    plru_lock_victim u_dut (
        .clk (clk), .rst (rst), .set_idx (set_idx),
        .hit_vld (hit_vld), .hit_way (hit_way),
        .fill_req (fill_req), .fill_instr (fill_instr),
        .lk_vld (lk_vld), .lk_set (lk_set), .lk_instr (lk_instr), .lk_way (lk_way),
        .cache_lock_instr (cache_lock_instr), .cache_lock_data (cache_lock_data),
        .flash_clr (flash_clr),
        .vic_vld (vic_vld), .vic_none (vic_none), .vic_way (vic_way),
        .flash_busy (flash_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fill_chk(input bit instr, input int set, input bit enone,
                            input int eway, input string tag);
        set_idx = 10'(set); fill_instr = instr; fill_req = 1'b1;
        @(posedge clk); @(negedge clk);
        fill_req = 1'b0;
        chk({tag, " vld"}, int'(vic_vld), 1);
        chk({tag, " none"}, int'(vic_none), int'(enone));
        if (!enone) chk({tag, " way"}, int'(vic_way), eway);
    endtask

    task automatic lock_op(input bit setv, input bit instr, input int set, input int way);
        set_idx = 10'(set); lk_set = setv; lk_instr = instr; lk_way = 3'(way); lk_vld = 1'b1;
        @(posedge clk); @(negedge clk);
        lk_vld = 1'b0;
    endtask

    task automatic hit_op(input int set, input int way);
        set_idx = 10'(set); hit_way = 3'(way); hit_vld = 1'b1;
        @(posedge clk); @(negedge clk);
        hit_vld = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 vld after reset", int'(vic_vld), 0);
        chk("R1 busy after reset", int'(flash_busy), 0);
        fill_chk(1'b0, 100, 1'b0, 0, "R1 first fill");

        // Vector table: R3 order, R4 hit, R6 fallback, R7 domains, R8 unlock, R13 sets
        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R3/R4/R6/R7/R8/R13 vec%0d", i);
            case (VECS[i].op)
                3'd0: fill_chk(1'b1, int'(VECS[i].set), VECS[i].enone, int'(VECS[i].eway), tg);
                3'd1: fill_chk(1'b0, int'(VECS[i].set), VECS[i].enone, int'(VECS[i].eway), tg);
                3'd2: hit_op(int'(VECS[i].set), int'(VECS[i].way));
                3'd3: lock_op(1'b1, 1'b1, int'(VECS[i].set), int'(VECS[i].way));
                3'd4: lock_op(1'b1, 1'b0, int'(VECS[i].set), int'(VECS[i].way));
                3'd5: lock_op(1'b0, 1'b1, int'(VECS[i].set), int'(VECS[i].way));
                default: lock_op(1'b0, 1'b0, int'(VECS[i].set), int'(VECS[i].way));
            endcase
        end

        // R9 all ways locked, no state change; R8 unlock restores one way
        for (int w = 0; w < 8; w++) lock_op(1'b1, 1'b0, 20, w);
        fill_chk(1'b0, 20, 1'b1, 0, "R9 all locked");
        fill_chk(1'b1, 20, 1'b0, 0, "R9 tree untouched");
        lock_op(1'b0, 1'b0, 20, 5);
        fill_chk(1'b0, 20, 1'b0, 5, "R8 unlocked way");

        // R10 whole-domain freeze
        cache_lock_data = 1'b1;
        fill_chk(1'b0, 30, 1'b1, 0, "R10 data frozen");
        fill_chk(1'b1, 30, 1'b0, 0, "R10 instr unaffected");
        cache_lock_data = 1'b0;
        fill_chk(1'b0, 30, 1'b0, 4, "R10 no state change");
        cache_lock_instr = 1'b1;
        fill_chk(1'b1, 31, 1'b1, 0, "R10 instr frozen");
        cache_lock_instr = 1'b0;

        // R5 fill and hit together
        set_idx = 10'd40; hit_way = 3'd4; hit_vld = 1'b1;
        fill_chk(1'b0, 40, 1'b0, 0, "R5 fill wins");
        hit_vld = 1'b0;
        fill_chk(1'b0, 40, 1'b0, 4, "R5 hit dropped");

        // R2 no response without request
        @(posedge clk); @(negedge clk);
        chk("R2 idle vld", int'(vic_vld), 0);

        // R11 / R12 flash clear sweep
        for (int w = 0; w < 8; w++) lock_op(1'b1, 1'b1, 50, w);
        for (int w = 0; w < 8; w++) lock_op(1'b1, 1'b0, 1023, w);
        fill_chk(1'b1, 50, 1'b1, 0, "R11 setup locked");
        flash_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        flash_clr = 1'b0;
        chk("R11 busy rises", int'(flash_busy), 1);
        fill_chk(1'b0, 60, 1'b1, 0, "R12 fill refused");
        lock_op(1'b1, 1'b0, 61, 0);
        begin
            int cnt;
            cnt = 0;
            while (flash_busy && cnt < 5000) begin
                cnt++;
                @(negedge clk);
            end
            chk("R11 busy length", cnt + 2, 1024);
        end
        fill_chk(1'b1, 50, 1'b0, 0, "R11 instr locks gone");
        fill_chk(1'b0, 1023, 1'b0, 0, "R11 data locks gone");
        fill_chk(1'b0, 61, 1'b0, 0, "R12 lock ignored");
        fill_chk(1'b0, 60, 1'b0, 0, "R12 tree untouched");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule